// File: doc/BRIEF.md
# Sticky PCI Error Status Register

This block holds the error flags of a PCI bridge for three bus fault conditions: a PERR# assertion driven by some other agent, a parity fault on data the bridge reads from the bus, and a parity fault on an address phase. A flag is set one clock after its event is seen. It then stays set until software writes a 1 to that bit position.

The flags survive the ordinary bus reset. Only the power-good reset clears them. Recovery code that runs after a forced bus reset can therefore still read why the error happened.

Each flag can be routed, through enable inputs, to a SERR# request and to a PERR# request. The address parity flag can reach only the SERR# request. Both requests are registered before they leave the block. Parity generation and checking on the bus are done elsewhere; this block sees only their result pulses.

Top module: `pci_err_status`

## Requirements
- R1: While the power-good reset `rst_ni` is low, the register reads 00h and both request outputs are low, asynchronously.
- R2: Bit 6 sets on the clock edge where `perr_seen_i` is high and `perr_self_i` is low. A PERR# that the bridge drives itself (`perr_self_i` high) does not set bit 6.
- R3: Bit 5 sets on the clock edge where `rd_par_err_i` is high.
- R4: Bit 4 sets on the clock edge where `addr_par_err_i` is high.
- R5: A write (`reg_wr_i` high) clears each of bits 6, 5 and 4 whose `reg_wdata_i` bit is 1. A 0 in a write data bit leaves that flag unchanged. Without a set event, a flag holds its value.
- R6: If a set event and a write-1 clear reach the same flag on the same edge, the flag ends up set.
- R7: A low `bus_rst_ni` neither clears nor blocks the flags. They keep their value during and after the bus reset, and events are still recorded while it is asserted.
- R8: Bit 7 and bits 3:0 always read 0. Writing 1 to them has no effect.
- R9: `serr_req_o` is, one clock after the flags, the OR of bit 6 AND `serr_en_i[2]`, bit 5 AND `serr_en_i[1]`, and bit 4 AND `serr_en_i[0]`.
- R10: `perr_req_o` is, one clock after the flags, the OR of bit 6 AND `perr_en_i[1]` and bit 5 AND `perr_en_i[0]`. Bit 4 never raises it.
- R11: On each clock edge where `bus_rst_ni` is low, both request outputs are loaded with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-good reset, active low, asynchronous |
| bus_rst_ni | input | 1 | Bus reset, active low, synchronous; affects only the requests |
| perr_seen_i | input | 1 | PERR# observed asserted on the bus |
| perr_self_i | input | 1 | This bridge is driving PERR# |
| rd_par_err_i | input | 1 | Parity fault on read data |
| addr_par_err_i | input | 1 | Parity fault on an address phase |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data; a 1 clears the matching flag |
| reg_rdata_o | output | 8 | Register contents |
| serr_en_i | input | 3 | SERR# enables for bits 6, 5, 4 (index 2, 1, 0) |
| perr_en_i | input | 2 | PERR# enables for bits 6, 5 (index 1, 0) |
| serr_req_o | output | 1 | Registered SERR# request |
| perr_req_o | output | 1 | Registered PERR# request |

## Verification
The assertions check the following on every cycle: that each flag sets after its event and clears after a write of 1 with no event present, that set beats clear, that a PERR# driven by the bridge itself never sets bit 6, that a flag is held across the bus reset, and that the requests are quiet after a bus-reset edge.

Only the bench's scenarios can show the remaining behaviour. This covers the exact routing of each flag to each request across the enable combinations, the bit-4 exclusion from PERR#, and the reserved bits reading 0 after writes. It also covers an asynchronous power-good reset arriving mid-run, and flags that were set before a bus reset still reading back after it ends.

// File: rtl/err_sts_pkg.sv
package err_sts_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_LSB  = 4;  // flags occupy bits 6:4
  localparam int unsigned FLAG_MSB  = FLAG_LSB + NUM_FLAGS - 1;
  localparam int unsigned IDX_ADDR  = 0;  // bit 4
  localparam int unsigned IDX_RDAT  = 1;  // bit 5
  localparam int unsigned IDX_PERR  = 2;  // bit 6
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/err_flag_cell.sv
module err_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // set has priority over clear
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/err_csr_port.sv
module err_csr_port
  import err_sts_pkg::*;
(
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  flag_vec_t        flags_i,
  output flag_vec_t        clr_o,
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NUM_FLAGS); i++) begin
      clr_o[i]              = reg_wr_i & reg_wdata_i[FLAG_LSB+i];
      rdata_o[FLAG_LSB + i] = flags_i[i];
    end
  end
endmodule

// File: rtl/err_req_route.sv
module err_req_route
  import err_sts_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bus_rst_ni,
  input  flag_vec_t flags_i,
  input  flag_vec_t en_i,
  output logic      req_o
);
  logic req_d;
  assign req_d = |(flags_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          req_o <= 1'b0;
    else if (!bus_rst_ni) req_o <= 1'b0;
    else                  req_o <= req_d;
  end

  a_r11_bus_rst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |=> !req_o);
  a_r9_no_flag_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == '0) |=> !req_o);
endmodule

// File: rtl/pci_err_status.sv
module pci_err_status
  import err_sts_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_ni,
  input  logic             perr_seen_i,
  input  logic             perr_self_i,
  input  logic             rd_par_err_i,
  input  logic             addr_par_err_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [2:0]       serr_en_i,
  input  logic [1:0]       perr_en_i,
  output logic             serr_req_o,
  output logic             perr_req_o
);
  flag_vec_t set_v, clr_v, flags, perr_en_v;

  always_comb begin
    set_v           = '0;
    set_v[IDX_PERR] = perr_seen_i & ~perr_self_i;
    set_v[IDX_RDAT] = rd_par_err_i;
    set_v[IDX_ADDR] = addr_par_err_i;
    perr_en_v           = '0;
    perr_en_v[IDX_PERR] = perr_en_i[1];
    perr_en_v[IDX_RDAT] = perr_en_i[0];
  end

  // bus reset deliberately not wired to the flags
  for (genvar g = 0; g < int'(NUM_FLAGS); g++) begin : g_flag
    err_flag_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (flags[g])
    );
  end

  err_csr_port u_csr (
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .flags_i    (flags),
    .clr_o      (clr_v),
    .rdata_o    (reg_rdata_o)
  );

  err_req_route u_serr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_ni(bus_rst_ni),
    .flags_i   (flags),
    .en_i      (serr_en_i),
    .req_o     (serr_req_o)
  );

  err_req_route u_perr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_ni(bus_rst_ni),
    .flags_i   (flags),
    .en_i      (perr_en_v),
    .req_o     (perr_req_o)
  );

  a_r2_self_perr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_self_i && !flags[IDX_PERR]) |=> !flags[IDX_PERR]);
  a_r7_bus_rst_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && set_v == '0 && !reg_wr_i) |=> $stable(reg_rdata_o));
  a_r4_addr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_par_err_i |=> reg_rdata_o[FLAG_LSB + IDX_ADDR]);
endmodule

// File: tb/pci_err_status_test.sv
module pci_err_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, bus_rst_n = 1'b1;
  logic perr_seen = 0, perr_self = 0, rd_par = 0, addr_par = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] serr_en = '0;
  logic [1:0] perr_en = '0;
  logic serr_req, perr_req;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_flags = '0;   // [2]=bit6 [1]=bit5 [0]=bit4
  logic m_serr = 0, m_perr = 0;

  always #10 clk = ~clk;

  pci_err_status uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_ni(bus_rst_n),
    .perr_seen_i(perr_seen), .perr_self_i(perr_self),
    .rd_par_err_i(rd_par), .addr_par_err_i(addr_par),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .serr_en_i(serr_en), .perr_en_i(perr_en),
    .serr_req_o(serr_req), .perr_req_o(perr_req)
  );

  function automatic logic [7:0] exp_rd(logic [2:0] f);
    return {1'b0, f, 4'b0000};
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (rdata !== exp_rd(m_flags)) begin
      n_bad++; $display("FAIL %s rdata act=%h exp=%h", tag, rdata, exp_rd(m_flags));
    end
    if (serr_req !== m_serr || perr_req !== m_perr) begin
      n_bad++; $display("FAIL %s req act=%b%b exp=%b%b", tag, serr_req, perr_req, m_serr, m_perr);
    end
  endtask

  // model one posedge from current inputs, then check at next negedge
  task automatic step(string tag);
    logic [2:0] s, c;
    s = {perr_seen & ~perr_self, rd_par, addr_par};
    c = wr ? wdata[6:4] : 3'b000;
    m_serr = bus_rst_n ? |(m_flags & serr_en) : 1'b0;
    m_perr = bus_rst_n ? |(m_flags[2:1] & perr_en) : 1'b0;
    m_flags = s | (m_flags & ~c);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle();
    perr_seen = 0; perr_self = 0; rd_par = 0; addr_par = 0; wr = 0; wdata = '0;
  endtask

  initial begin
    #3_000_000;
    n_bad++; $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    step("R1 idle after reset");

    // R2: self-driven PERR# ignored, foreign sets
    perr_seen = 1; perr_self = 1; step("R2 self");
    perr_self = 0; step("R2 foreign"); idle();
    // R3, R4
    rd_par = 1; step("R3 rd parity"); idle();
    addr_par = 1; step("R4 addr parity"); idle();
    // R5: write 0 no effect, then write 1 to bit 5
    wr = 1; wdata = 8'h00; step("R5 write zero"); idle();
    wr = 1; wdata = 8'h20; step("R5 clear bit5"); idle();
    // R8: reserved bits written
    wr = 1; wdata = 8'h8F; step("R8 reserved write"); idle();
    // R6: set and clear same cycle on bit 4
    wr = 1; wdata = 8'h10; addr_par = 1; step("R6 set wins"); idle();
    // R9/R10 routing
    serr_en = 3'b001; perr_en = 2'b11; wr = 1; wdata = 8'h40; step("R10 setup");
    idle(); step("R9 bit4 serr"); step("R10 bit4 no perr");
    // R7/R11: bus reset keeps flags, records, quiets requests
    rd_par = 1; serr_en = 3'b111; step("R9 bit5 serr");
    bus_rst_n = 0; idle(); step("R11 bus reset");
    perr_seen = 1; step("R7 record during bus reset"); idle();
    step("R7 hold during bus reset");
    bus_rst_n = 1; step("R7 after bus reset"); step("R9 R10 after bus reset");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      perr_seen = ($urandom % 6) == 0;
      perr_self = $urandom % 2;
      rd_par    = ($urandom % 7) == 0;
      addr_par  = ($urandom % 7) == 0;
      wr        = ($urandom % 4) == 0;
      wdata     = 8'($urandom);
      serr_en   = 3'($urandom);
      perr_en   = 2'($urandom);
      bus_rst_n = ($urandom % 10) != 0;
      step("R2 R3 R4 R5 R6 R7 R9 R10 R11 random");
    end

    // R1: power-good reset mid-run, asynchronous
    idle(); bus_rst_n = 1; addr_par = 1; rd_par = 1; step("R3 R4 pre-reset");
    idle(); #2 rst_n = 0; #1;
    m_flags = '0; m_serr = 0; m_perr = 0;
    check("R1 async power-good");
    @(negedge clk); rst_n = 1;
    step("R1 after power-good");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule